// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block watches inbound memory writes arriving from the bus side and picks out those that are message-signalled interrupts. A write counts as an interrupt message when its full 64-bit address equals a target address that software has programmed. The data of that write is taken as a vector number. Each vector has an enable bit, a mask bit and a status bit, and the vectors are arranged in groups of 32. A vector that is enabled latches its status bit when its message arrives. The block drives one interrupt line toward the host. That line is high while any latched vector is not masked.

Software reaches the block through a simple word-wide register port. It uses the port to program the target address, to enable and mask vectors, and to service latched vectors by writing 1 to their status bits. A read returns its data one cycle after the request. The default build has 8 groups, which gives 256 vectors.

Top module: `msi_irq_ctrl`

## Requirements
- R1: The target address low word is at register offset 0x820 and the high word is at 0x824. Both are read/write. `reg_rdata` carries the read value in the cycle after `reg_rd_en` and is zero in any other cycle.
- R2: Group g has its enable word at 0x828+12*g, its mask word at 0x82C+12*g and its status word at 0x830+12*g. Enable and mask are read/write. A read of any unmapped offset returns zero. Bits [1:0] of the offset are ignored.
- R3: An inbound write is an interrupt message only when all 64 address bits equal {high word, low word}. Any other inbound write leaves every status bit unchanged.
- R4: A message with data value v, where v is below 256, sets status bit v mod 32 of group v/32 at the next clock edge, provided that vector's enable bit is set.
- R5: A message to a vector whose enable bit is clear records nothing.
- R6: A message whose data value is 256 or more is dropped.
- R7: Writing the status word clears each bit written as 1. Each bit written as 0 is left unchanged.
- R8: When a message and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Mask bits do not stop a status bit from latching. They only stop that bit from driving the interrupt.
- R10: `irq_out` is a register. At each clock edge it loads the OR, over all vectors, of status AND NOT mask, so it follows a status or mask change one cycle later.
- R11: After a synchronous reset, every register reads zero and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_wr_valid | input | 1 | An inbound memory write is present this cycle |
| in_wr_addr | input | 64 | Address of the inbound write |
| in_wr_data | input | 32 | Data of the inbound write (the vector number) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after the read |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
The bench checks group boundaries: vectors 31, 32, 255 and the out-of-range value 256. A design that divides or masks the vector number wrongly would set a bit in the wrong group, or would wrap 256 onto vector 0. The bench sends writes that match only the low address word, and a design that compares only 32 address bits would latch them. It collides a message with a write-1-to-clear on the same bit, and sets masked vectors. A design that lets the clear win would lose the message, and one that gates latching with the mask would never show status. A long mixed stream then compares `irq_out` and every read against a behavioural model on every cycle, which catches an interrupt line that is off by a cycle.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int REG_AW      = 12;
  localparam int REG_DW      = 32;
  localparam int VEC_PER_GRP = 32;
  localparam int GRP_STRIDE  = 12;
  localparam logic [REG_AW-1:0] TGT_LO_OFF = 12'h820;
  localparam logic [REG_AW-1:0] TGT_HI_OFF = 12'h824;
  localparam logic [REG_AW-1:0] GRP_BASE   = 12'h828;

  typedef enum logic [1:0] {
    KIND_ENABLE = 2'd0,
    KIND_MASK   = 2'd1,
    KIND_STATUS = 2'd2,
    KIND_NONE   = 2'd3
  } grp_kind_e;
endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_pkg::*;
#(
  parameter int GROUPS = 8,
  localparam int GIW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic [REG_AW-1:0] addr,
  output logic              hit_lo,
  output logic              hit_hi,
  output logic              hit_grp,
  output logic [GIW-1:0]    grp_idx,
  output grp_kind_e         kind
);
  localparam int WORDS_PER_GRP = GRP_STRIDE / 4;
  localparam int WW = REG_AW - 2;

  logic [REG_AW-1:0] off;
  logic [WW-1:0]     word;
  logic [WW-1:0]     slot;

  always_comb begin
    off     = addr - GRP_BASE;
    word    = off[REG_AW-1:2];
    hit_lo  = (addr[REG_AW-1:2] == TGT_LO_OFF[REG_AW-1:2]);
    hit_hi  = (addr[REG_AW-1:2] == TGT_HI_OFF[REG_AW-1:2]);
    hit_grp = (addr[REG_AW-1:2] >= GRP_BASE[REG_AW-1:2]) &&
              (word < WW'(WORDS_PER_GRP * GROUPS));
    grp_idx = GIW'(word / WW'(WORDS_PER_GRP));
    slot    = word % WW'(WORDS_PER_GRP);
    kind    = KIND_NONE;
    if (hit_grp) begin
      case (slot[1:0])
        2'd0:    kind = KIND_ENABLE;
        2'd1:    kind = KIND_MASK;
        2'd2:    kind = KIND_STATUS;
        default: kind = KIND_NONE;
      endcase
    end
  end
endmodule

// File: rtl/msi_capture.sv
module msi_capture
  import msi_pkg::*;
#(
  parameter int GROUPS = 8,
  localparam int VECS = GROUPS * VEC_PER_GRP,
  localparam int VW   = $clog2(VECS)
) (
  input  logic              in_wr_valid,
  input  logic [63:0]       in_wr_addr,
  input  logic [REG_DW-1:0] in_wr_data,
  input  logic [63:0]       target_addr,
  output logic [VECS-1:0]   set_vec
);
  logic addr_match;
  logic in_range;

  always_comb begin
    addr_match = in_wr_valid && (in_wr_addr == target_addr);
    in_range   = (in_wr_data < REG_DW'(VECS));
    set_vec    = '0;
    if (addr_match && in_range)
      set_vec[in_wr_data[VW-1:0]] = 1'b1;
  end
endmodule

// File: rtl/msi_vec_group.sv
module msi_vec_group
  import msi_pkg::*;
#(
  parameter int W = VEC_PER_GRP
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] wdata,
  input  logic         wr_enable,
  input  logic         wr_mask,
  input  logic         wr_status,
  output logic [W-1:0] enable_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] status_q,
  output logic         pending
);
  logic [W-1:0] clr_bits;
  logic [W-1:0] status_d;

  always_comb begin
    clr_bits = wr_status ? wdata : '0;
    status_d = (status_q & ~clr_bits) | (set_bits & enable_q);
    pending  = |(status_q & ~mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (wr_enable) enable_q <= wdata;
      if (wr_mask)   mask_q   <= wdata;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msi_pkg::*;
#(
  parameter int GROUPS = 8,
  localparam int VECS = GROUPS * VEC_PER_GRP,
  localparam int GIW  = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_wr_valid,
  input  logic [63:0]       in_wr_addr,
  input  logic [REG_DW-1:0] in_wr_data,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq_out
);
  logic [REG_DW-1:0] tgt_lo_q, tgt_hi_q;
  logic [63:0]       target_addr;
  logic              dec_lo, dec_hi, dec_grp;
  logic [GIW-1:0]    dec_idx;
  grp_kind_e         dec_kind;
  logic [VECS-1:0]   set_vec;
  logic [VECS-1:0]   status_all, mask_all, enable_all;
  logic [GROUPS-1:0] pend_vec;
  logic [VEC_PER_GRP-1:0] en_arr [GROUPS];
  logic [VEC_PER_GRP-1:0] mk_arr [GROUPS];
  logic [VEC_PER_GRP-1:0] st_arr [GROUPS];
  logic [REG_DW-1:0] rd_mux;
  logic [REG_DW-1:0] rdata_q;
  logic              irq_q;

  assign target_addr = {tgt_hi_q, tgt_lo_q};

  msi_reg_decode #(.GROUPS(GROUPS)) u_dec (
    .addr    (reg_addr),
    .hit_lo  (dec_lo),
    .hit_hi  (dec_hi),
    .hit_grp (dec_grp),
    .grp_idx (dec_idx),
    .kind    (dec_kind)
  );

  msi_capture #(.GROUPS(GROUPS)) u_cap (
    .in_wr_valid (in_wr_valid),
    .in_wr_addr  (in_wr_addr),
    .in_wr_data  (in_wr_data),
    .target_addr (target_addr),
    .set_vec     (set_vec)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic sel;
    assign sel = reg_wr_en && dec_grp && (dec_idx == GIW'(g));
    msi_vec_group #(.W(VEC_PER_GRP)) u_grp (
      .clk       (clk),
      .rst       (rst),
      .set_bits  (set_vec[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .wdata     (reg_wdata),
      .wr_enable (sel && (dec_kind == KIND_ENABLE)),
      .wr_mask   (sel && (dec_kind == KIND_MASK)),
      .wr_status (sel && (dec_kind == KIND_STATUS)),
      .enable_q  (en_arr[g]),
      .mask_q    (mk_arr[g]),
      .status_q  (st_arr[g]),
      .pending   (pend_vec[g])
    );
    assign status_all[g*VEC_PER_GRP +: VEC_PER_GRP] = st_arr[g];
    assign mask_all[g*VEC_PER_GRP +: VEC_PER_GRP]   = mk_arr[g];
    assign enable_all[g*VEC_PER_GRP +: VEC_PER_GRP] = en_arr[g];
  end

  always_comb begin
    rd_mux = '0;
    if (dec_lo)
      rd_mux = tgt_lo_q;
    else if (dec_hi)
      rd_mux = tgt_hi_q;
    else if (dec_grp) begin
      case (dec_kind)
        KIND_ENABLE: rd_mux = en_arr[dec_idx];
        KIND_MASK:   rd_mux = mk_arr[dec_idx];
        KIND_STATUS: rd_mux = st_arr[dec_idx];
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (reg_wr_en && dec_lo) tgt_lo_q <= reg_wdata;
      if (reg_wr_en && dec_hi) tgt_hi_q <= reg_wdata;
      rdata_q <= reg_rd_en ? rd_mux : '0;
      irq_q   <= |pend_vec;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/msi_irq_ctrl_chk.sv
module msi_irq_ctrl_chk
  import msi_pkg::*;
#(
  parameter int GROUPS = 8,
  localparam int VECS = GROUPS * VEC_PER_GRP,
  localparam int VW   = $clog2(VECS)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_wr_valid,
  input logic [63:0]       in_wr_addr,
  input logic [REG_DW-1:0] in_wr_data,
  input logic              reg_wr_en,
  input logic              irq_out,
  input logic [63:0]       target_addr,
  input logic [VECS-1:0]   status_all,
  input logic [VECS-1:0]   mask_all,
  input logic [VECS-1:0]   enable_all
);
  // R10
  irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == |($past(status_all) & ~$past(mask_all))));

  // R3
  addr_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (in_wr_valid && (in_wr_addr != target_addr) && !reg_wr_en) |=> $stable(status_all));

  // R6
  big_vec_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_wr_valid && (in_wr_data >= REG_DW'(VECS)) && !reg_wr_en) |=> $stable(status_all));

  // R5
  disabled_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_all & ~$past(status_all) & ~$past(enable_all)) == '0));

  // R8 R9
  enabled_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (in_wr_valid && (in_wr_addr == target_addr) && (in_wr_data < REG_DW'(VECS)) &&
     enable_all[in_wr_data[VW-1:0]])
    |=> status_all[$past(in_wr_data[VW-1:0])]);
endmodule

bind msi_irq_ctrl msi_irq_ctrl_chk #(.GROUPS(GROUPS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_wr_valid (in_wr_valid),
  .in_wr_addr  (in_wr_addr),
  .in_wr_data  (in_wr_data),
  .reg_wr_en   (reg_wr_en),
  .irq_out     (irq_out),
  .target_addr (target_addr),
  .status_all  (status_all),
  .mask_all    (mask_all),
  .enable_all  (enable_all)
);

// File: tb/msi_irq_ctrl_tb.sv
module msi_irq_ctrl_tb;
  localparam int G = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_wr_valid;
  logic [63:0] in_wr_addr;
  logic [31:0] in_wr_data;
  logic        reg_wr_en, reg_rd_en;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R11";

  logic [31:0] m_en [G];
  logic [31:0] m_mk [G];
  logic [31:0] m_st [G];
  logic [31:0] m_lo, m_hi;

  always #5 clk = ~clk;

  msi_irq_ctrl #(.GROUPS(G)) u_dut (
    .clk(clk), .rst(rst), .in_wr_valid(in_wr_valid), .in_wr_addr(in_wr_addr),
    .in_wr_data(in_wr_data), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(logic [11:0] a);
    int w;
    w = int'(a[11:2]);
    if (w == 'h820 / 4) return m_lo;
    if (w == 'h824 / 4) return m_hi;
    if (w >= 'h828 / 4 && w < 'h828 / 4 + 3 * G) begin
      int k;
      k = w - 'h828 / 4;
      case (k % 3)
        0: return m_en[k / 3];
        1: return m_mk[k / 3];
        default: return m_st[k / 3];
      endcase
    end
    return 32'h0;
  endfunction

  task automatic idle();
    in_wr_valid = 0; in_wr_addr = '0; in_wr_data = '0;
    reg_wr_en = 0; reg_rd_en = 0; reg_addr = '0; reg_wdata = '0;
  endtask

  // One clock: inputs already applied; update model from pre-edge state, then compare.
  task automatic cyc();
    logic exp_irq;
    logic [31:0] exp_rd;
    logic [31:0] clr [G];
    @(posedge clk);
    #1;
    exp_irq = 1'b0;
    exp_rd  = 32'h0;
    if (rst) begin
      for (int g = 0; g < G; g++) begin m_en[g] = 0; m_mk[g] = 0; m_st[g] = 0; end
      m_lo = 0; m_hi = 0;
    end else begin
      for (int g = 0; g < G; g++) begin
        if ((m_st[g] & ~m_mk[g]) != 0) exp_irq = 1'b1;
        clr[g] = 32'h0;
      end
      if (reg_rd_en) exp_rd = model_read(reg_addr);
      if (in_wr_valid && in_wr_addr == {m_hi, m_lo} && in_wr_data < 32'(G * 32)) begin
        int v;
        v = int'(in_wr_data);
        if (m_en[v / 32][v % 32]) m_st[v / 32][v % 32] = 1'b1;
        // the set lands after the clear below only if applied later; handle via clr mask
        if (m_en[v / 32][v % 32]) clr[v / 32][v % 32] = 1'b1;
      end
      if (reg_wr_en) begin
        int w;
        w = int'(reg_addr[11:2]);
        if (w == 'h820 / 4) m_lo = reg_wdata;
        else if (w == 'h824 / 4) m_hi = reg_wdata;
        else if (w >= 'h828 / 4 && w < 'h828 / 4 + 3 * G) begin
          int k;
          k = w - 'h828 / 4;
          case (k % 3)
            0: m_en[k / 3] = reg_wdata;
            1: m_mk[k / 3] = reg_wdata;
            default: m_st[k / 3] = m_st[k / 3] & (~reg_wdata | clr[k / 3]);
          endcase
        end
      end
    end
    cmp("R10", {31'b0, irq_out}, {31'b0, exp_irq});
    cmp(cur_req, reg_rdata, exp_rd);
    idle();
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d; cyc();
  endtask
  task automatic rd(logic [11:0] a);
    reg_rd_en = 1; reg_addr = a; cyc(); cyc();
  endtask
  task automatic msi(logic [63:0] a, logic [31:0] d);
    in_wr_valid = 1; in_wr_addr = a; in_wr_data = d; cyc();
  endtask
  function automatic logic [11:0] gofs(int g, int kind);
    return 12'(32'h828 + 12 * g + 4 * kind);
  endfunction
  task automatic clear_all();
    for (int g = 0; g < G; g++) wr(gofs(g, 2), 32'hFFFF_FFFF);
  endtask

  localparam logic [63:0] TGT = 64'h0000_0001_FEE0_0040;

  initial begin
    idle();
    rst = 1;
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R11: everything zero after reset
    cur_req = "R11";
    rd(12'h820); rd(12'h824);
    for (int g = 0; g < G; g++) for (int k = 0; k < 3; k++) rd(gofs(g, k));
    // R1: target address registers
    cur_req = "R1";
    wr(12'h820, TGT[31:0]); wr(12'h824, TGT[63:32]);
    rd(12'h820); rd(12'h824);
    // R2: group layout and unmapped reads
    cur_req = "R2";
    for (int g = 0; g < G; g++) wr(gofs(g, 1), 32'hA5A5_0000 | 32'(g));
    for (int g = 0; g < G; g++) rd(gofs(g, 1));
    wr(gofs(3, 0), 32'h1234_5678); rd(gofs(3, 0)); rd(gofs(3, 0) + 12'd2);
    rd(12'h81C); rd(12'h88C); rd(12'hFFC); rd(12'h000);
    for (int g = 0; g < G; g++) wr(gofs(g, 1), 32'h0);
    // R4: vector to group/bit mapping at boundaries
    cur_req = "R4";
    wr(gofs(0, 0), 32'hFFFF_FFFF); wr(gofs(1, 0), 32'hFFFF_FFFF); wr(gofs(7, 0), 32'hFFFF_FFFF);
    msi(TGT, 5); msi(TGT, 31); msi(TGT, 32); msi(TGT, 255);
    rd(gofs(0, 2)); rd(gofs(1, 2)); rd(gofs(7, 2));
    // R5: disabled vector not recorded
    cur_req = "R5";
    wr(gofs(2, 0), 32'hFFFF_FFFE);
    msi(TGT, 64); msi(TGT, 70); rd(gofs(2, 2));
    // R3: partial address matches ignored
    cur_req = "R3";
    msi({32'h0000_0002, TGT[31:0]}, 65); msi({TGT[63:32], 32'hFEE0_0044}, 66);
    rd(gofs(2, 2));
    // R6: out-of-range vector numbers dropped
    cur_req = "R6";
    clear_all();
    msi(TGT, 256); msi(TGT, 32'h0000_0105); msi(TGT, 32'hFFFF_FFFF);
    rd(gofs(0, 2)); rd(gofs(1, 2));
    // R9: masked vectors still latch, irq stays low
    cur_req = "R9";
    wr(gofs(0, 1), 32'h0000_0020);
    msi(TGT, 5); cyc(); cyc(); rd(gofs(0, 2));
    wr(gofs(0, 1), 32'h0); cyc(); cyc();
    // R7: write-1-to-clear, zeros leave bits alone
    cur_req = "R7";
    msi(TGT, 1); msi(TGT, 2); msi(TGT, 3);
    wr(gofs(0, 2), 32'h0000_0004); rd(gofs(0, 2));
    wr(gofs(0, 2), 32'h0); rd(gofs(0, 2));
    // R8: set wins over same-cycle clear
    cur_req = "R8";
    in_wr_valid = 1; in_wr_addr = TGT; in_wr_data = 3;
    reg_wr_en = 1; reg_addr = gofs(0, 2); reg_wdata = 32'hFFFF_FFFF;
    cyc(); rd(gofs(0, 2));
    clear_all(); cyc(); cyc();
    // R10: mixed traffic compared every cycle
    cur_req = "R10";
    for (int g = 0; g < G; g++) wr(gofs(g, 0), 32'hF0F0_FFFF ^ 32'(g * 32'h1111));
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4) begin
        in_wr_valid = 1;
        in_wr_addr = ($urandom_range(0, 7) == 0) ? (TGT ^ 64'h1_0000_0000) : TGT;
        in_wr_data = 32'($urandom_range(0, 270));
      end
      if (op >= 4 && op < 6) begin
        reg_wr_en = 1;
        reg_addr = gofs(int'($urandom_range(0, G - 1)), int'($urandom_range(1, 2)));
        reg_wdata = $urandom & $urandom;
      end
      if (op >= 5) begin
        reg_rd_en = 1;
        reg_addr = gofs(int'($urandom_range(0, G - 1)), int'($urandom_range(0, 2)));
        if (op == 5) reg_wr_en = 1;
      end
      cyc();
    end
    cyc(); cyc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule